// File: doc/BRIEF.md
# Four-Channel DMA Control Register Bank

This block holds the shared control state of a four-channel DMA engine: the command byte, the per-channel mode bytes, the channel mask, and the status byte. The status byte packs a terminal-count flag and a pending-request flag for each channel. Software reaches the block through a byte-wide register port with a 3-bit offset. Write and read decode separately. The channel address and count registers sit outside the block and share only the byte pointer flag.

Hardware request sources raise and drop per-channel requests with hold and release pulses. The channel registers report terminal count with one-cycle pulses. From the mask and the pending requests the block picks one channel to service. It presents that choice as a one-hot grant that changes one clock edge after the state that caused it. Each cycle the grant stays on stands for one transfer unit.

Top module: `dma_ctrl_bank`

## Requirements
- R1: A write to offset 0 with data 8'h00 or 8'h04 stores the value as the command byte, and the byte is seen on `cmdOut` after the next clock edge.
- R2: A write to offset 0 whose data has any bit set other than bit 2 leaves the command byte unchanged.
- R3: A write to offset 1 selects a channel with data[1:0]. Data bit 2 sets (1) or clears (0) that channel's request flag, which is status bit channel+4. The same write always clears that channel's terminal-count flag, status bit channel.
- R4: A write to offset 2 selects a channel with data[1:0]. Data bit 2 sets (1) or clears (0) that channel's mask bit.
- R5: A write to offset 3 stores the whole data byte as the mode byte of the channel in data[1:0]. Mode byte n drives `modeFlat[8n+7:8n]`, with transfer type in bits [3:2], auto-init in bit 4, decrement in bit 5 and operating mode in bits [7:6]. Mode bytes reset to 0 on hardware reset only.
- R6: Hardware reset, and a write to offset 5, set all four mask bits and zero the status byte, the command byte and the byte pointer.
- R7: A read of offset 0 returns the status byte on `rdData` in the same cycle. The tc flags are bits [3:0] and the request flags are bits [7:4]. At the next edge bits [3:0] clear and bits [7:4] are kept.
- R8: A read of offset 1 returns the mask as {4'b0, mask[3:0]}. A read of any other offset returns 8'h00, and `rdData` is 8'h00 while `rdEn` is low.
- R9: A write to offset 6 clears all mask bits. A write to offset 7 loads the mask from data[3:0].
- R10: A `dreqRelease[n]` pulse clears request flag n and a `dreqHold[n]` pulse sets it. Both are applied after any register write in the same cycle, and hold wins over release.
- R11: A `tcIn[n]` pulse sets terminal-count flag n. It takes priority over a clear from a status read, a request write or a reset write in the same cycle.
- R12: `grantVec` is one-hot on the lowest-numbered channel whose mask bit is clear and whose request flag is set. It is all zero when no channel qualifies.
- R13: A `ptrToggle` pulse inverts `bytePtr`. A write to offset 4 (or 5) clears it, and the clear wins over a toggle in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regOffset | input | 3 | Register offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle of `rdEn` |
| ptrToggle | input | 1 | Flip request from the channel registers |
| bytePtr | output | 1 | Low/high byte pointer for channel registers |
| dreqHold | input | 4 | Per-channel request raise pulses |
| dreqRelease | input | 4 | Per-channel request drop pulses |
| tcIn | input | 4 | Per-channel terminal-count pulses |
| cmdOut | output | 8 | Stored command byte |
| modeFlat | output | 32 | Four mode bytes, channel 0 in the low byte |
| grantVec | output | 4 | One-hot service grant |

## Verification
Read data is combinational, so the bench compares `rdData` 1 ns after driving a read, before the clock edge. The compare uses the model state from before the edge. Every stored effect passes through one register stage: command, mode, mask, status and pointer all change at the edge that samples the stimulus. The grant is decoded directly from that state, so it is also due exactly one edge later. The bench applies its reference update at that edge and compares `cmdOut`, `modeFlat`, `grantVec` and `bytePtr` 2 ns after it. Mask and status are observed through reads in later cycles.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;

  localparam logic [2:0] OFS_CMD     = 3'd0;
  localparam logic [2:0] OFS_REQ     = 3'd1;
  localparam logic [2:0] OFS_MASK1   = 3'd2;
  localparam logic [2:0] OFS_MODE    = 3'd3;
  localparam logic [2:0] OFS_PTRCLR  = 3'd4;
  localparam logic [2:0] OFS_RESET   = 3'd5;
  localparam logic [2:0] OFS_UNMASK  = 3'd6;
  localparam logic [2:0] OFS_MASKALL = 3'd7;

  localparam logic [2:0] OFS_RD_STAT = 3'd0;
  localparam logic [2:0] OFS_RD_MASK = 3'd1;

  // Only this command bit may be set in an accepted command byte
  localparam logic [7:0] CMD_ALLOWED = 8'h04;

  typedef struct packed {
    logic cmdWr;
    logic reqWr;
    logic maskWr;
    logic modeWr;
    logic ptrClr;
    logic masterClr;
    logic maskClrAll;
    logic maskWrAll;
    logic rdStatus;
    logic rdMask;
  } ctrlStrobes_t;

endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
  import dma_ctrl_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regOffset,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobes_t      strobes
);

  localparam logic [DATA_W-1:0] CMD_FORBID = ~DATA_W'(CMD_ALLOWED);

  logic cmdAccept;

  assign cmdAccept = ((wrData & CMD_FORBID) == '0);

  always_comb begin
    strobes = '0;
    if (wrEn) begin
      case (regOffset)
        ADDR_W'(OFS_CMD):     strobes.cmdWr      = cmdAccept;
        ADDR_W'(OFS_REQ):     strobes.reqWr      = 1'b1;
        ADDR_W'(OFS_MASK1):   strobes.maskWr     = 1'b1;
        ADDR_W'(OFS_MODE):    strobes.modeWr     = 1'b1;
        ADDR_W'(OFS_PTRCLR):  strobes.ptrClr     = 1'b1;
        ADDR_W'(OFS_RESET):   strobes.masterClr  = 1'b1;
        ADDR_W'(OFS_UNMASK):  strobes.maskClrAll = 1'b1;
        ADDR_W'(OFS_MASKALL): strobes.maskWrAll  = 1'b1;
        default: ;
      endcase
    end
    if (rdEn) begin
      strobes.rdStatus = (regOffset == ADDR_W'(OFS_RD_STAT));
      strobes.rdMask   = (regOffset == ADDR_W'(OFS_RD_MASK));
    end
  end

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [NUM_CH-1:0]        dreqHold,
  input  logic [NUM_CH-1:0]        dreqRelease,
  input  logic [NUM_CH-1:0]        tcIn,
  input  logic                     ptrToggle,
  output logic [NUM_CH-1:0]        maskQ,
  output logic [2*NUM_CH-1:0]      statusQ,
  output logic [DATA_W-1:0]        cmdQ,
  output logic [NUM_CH*DATA_W-1:0] modeFlat,
  output logic                     bytePtr,
  output logic [DATA_W-1:0]        rdData
);

  localparam int CH_W = $clog2(NUM_CH);

  logic [CH_W-1:0]   chSel;
  logic              setBit;
  logic [NUM_CH-1:0] maskN, reqN, tcN;
  logic [DATA_W-1:0] cmdN;
  logic              ptrN;

  assign chSel  = wrData[CH_W-1:0];
  assign setBit = wrData[CH_W];

  always_comb begin
    maskN = maskQ;
    reqN  = statusQ[2*NUM_CH-1:NUM_CH];
    tcN   = statusQ[NUM_CH-1:0];
    cmdN  = cmdQ;
    ptrN  = bytePtr ^ ptrToggle;
    if (strobes.cmdWr) cmdN = wrData;
    if (strobes.reqWr) begin
      reqN[chSel] = setBit;
      tcN[chSel]  = 1'b0;
    end
    if (strobes.maskWr) maskN[chSel] = setBit;
    if (strobes.ptrClr) ptrN = 1'b0;
    if (strobes.masterClr) begin
      ptrN  = 1'b0;
      maskN = '1;
      reqN  = '0;
      tcN   = '0;
      cmdN  = '0;
    end
    if (strobes.maskClrAll) maskN = '0;
    if (strobes.maskWrAll) maskN = wrData[NUM_CH-1:0];
    if (strobes.rdStatus) tcN = '0;
    // hardware events land after software effects
    reqN = (reqN & ~dreqRelease) | dreqHold;
    tcN  = tcN | tcIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '1;
      statusQ <= '0;
      cmdQ    <= '0;
      bytePtr <= 1'b0;
    end else begin
      maskQ   <= maskN;
      statusQ <= {reqN, tcN};
      cmdQ    <= cmdN;
      bytePtr <= ptrN;
    end
  end

  // one mode byte per channel
  for (genvar g = 0; g < NUM_CH; g++) begin : gMode
    logic [DATA_W-1:0] modeQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeQ <= '0;
      end else if (strobes.modeWr && (chSel == CH_W'(g))) begin
        modeQ <= wrData;
      end
    end
    assign modeFlat[g*DATA_W +: DATA_W] = modeQ;
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdStatus) rdData = DATA_W'(statusQ);
    if (strobes.rdMask)   rdData = DATA_W'(maskQ);
  end

endmodule

// File: rtl/dma_ctrl_arb.sv
module dma_ctrl_arb #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0]   maskQ,
  input  logic [2*NUM_CH-1:0] statusQ,
  output logic [NUM_CH-1:0]   grantVec
);

  logic [NUM_CH-1:0] eligible;
  logic              found;

  assign eligible = ~maskQ & statusQ[2*NUM_CH-1:NUM_CH];

  always_comb begin
    grantVec = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (eligible[i] && !found) begin
        grantVec[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_ctrl_bank.sv
module dma_ctrl_bank
  import dma_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        regOffset,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  input  logic                     ptrToggle,
  output logic                     bytePtr,
  input  logic [NUM_CH-1:0]        dreqHold,
  input  logic [NUM_CH-1:0]        dreqRelease,
  input  logic [NUM_CH-1:0]        tcIn,
  output logic [DATA_W-1:0]        cmdOut,
  output logic [NUM_CH*DATA_W-1:0] modeFlat,
  output logic [NUM_CH-1:0]        grantVec
);

  ctrlStrobes_t        strobes;
  logic [NUM_CH-1:0]   maskQ;
  logic [2*NUM_CH-1:0] statusQ;

  dma_ctrl_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .wrEn(wrEn), .rdEn(rdEn), .regOffset(regOffset), .wrData(wrData),
    .strobes(strobes)
  );

  dma_ctrl_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .dreqHold(dreqHold), .dreqRelease(dreqRelease), .tcIn(tcIn),
    .ptrToggle(ptrToggle), .maskQ(maskQ), .statusQ(statusQ),
    .cmdQ(cmdOut), .modeFlat(modeFlat), .bytePtr(bytePtr), .rdData(rdData)
  );

  dma_ctrl_arb #(.NUM_CH(NUM_CH)) u_arb (
    .maskQ(maskQ), .statusQ(statusQ), .grantVec(grantVec)
  );

endmodule

// File: rtl/dma_ctrl_bank_chk.sv
module dma_ctrl_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   regOffset,
  input logic [DATA_W-1:0]   wrData,
  input logic [NUM_CH-1:0]   dreqHold,
  input logic [NUM_CH-1:0]   tcIn,
  input logic [NUM_CH-1:0]   maskQ,
  input logic [2*NUM_CH-1:0] statusQ,
  input logic [DATA_W-1:0]   cmdOut,
  input logic [NUM_CH-1:0]   grantVec
);

  AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regOffset == ADDR_W'(0) && (wrData & ~DATA_W'(8'h04)) != '0)
      |=> cmdOut == $past(cmdOut)); // R2

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regOffset == ADDR_W'(5) && dreqHold == '0 && tcIn == '0)
      |=> (maskQ == '1 && statusQ == '0 && cmdOut == '0)); // R6

  AST_STAT_RD_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regOffset == ADDR_W'(0) && tcIn == '0)
      |=> statusQ[NUM_CH-1:0] == '0); // R7

  AST_TC_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (tcIn != '0) |=> ((statusQ[NUM_CH-1:0] & $past(tcIn)) == $past(tcIn))); // R11

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec)); // R12

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec != '0)
      |-> ((grantVec & ~maskQ & statusQ[2*NUM_CH-1:NUM_CH]) == grantVec)); // R12

endmodule

bind dma_ctrl_bank dma_ctrl_bank_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regOffset(regOffset),
  .wrData(wrData), .dreqHold(dreqHold), .tcIn(tcIn), .maskQ(maskQ),
  .statusQ(statusQ), .cmdOut(cmdOut), .grantVec(grantVec)
);

// File: tb/test_dma_ctrl_bank.sv
`timescale 1ns/1ps
module test_dma_ctrl_bank;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn, rdEn, ptrToggle;
  logic [2:0]  regOffset;
  logic [7:0]  wrData;
  logic [3:0]  dreqHold, dreqRelease, tcIn;
  logic [7:0]  rdData, cmdOut;
  logic [31:0] modeFlat;
  logic [3:0]  grantVec;
  logic        bytePtr;

  always #5 clk = ~clk;

  dma_ctrl_bank i_dma_ctrl_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regOffset(regOffset),
    .wrData(wrData), .rdData(rdData), .ptrToggle(ptrToggle), .bytePtr(bytePtr),
    .dreqHold(dreqHold), .dreqRelease(dreqRelease), .tcIn(tcIn),
    .cmdOut(cmdOut), .modeFlat(modeFlat), .grantVec(grantVec)
  );

  int errs = 0;
  int checks = 0;

  // reference state
  logic [3:0] mMask;
  logic [7:0] mStat;
  logic [7:0] mCmd;
  logic [7:0] mMode [4];
  logic       mPtr;

  function automatic logic [7:0] expRead(input logic [2:0] off);
    if (off == 3'd0) return mStat;
    if (off == 3'd1) return {4'b0, mMask};
    return 8'h00;
  endfunction

  function automatic logic [3:0] expGrant();
    logic [3:0] el;
    el = ~mMask & mStat[7:4];
    for (int i = 0; i < 4; i++) if (el[i]) return 4'(1 << i);
    return 4'b0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mMask = 4'hF; mStat = 8'h00; mCmd = 8'h00; mPtr = 1'b0;
    for (int i = 0; i < 4; i++) mMode[i] = 8'h00;
  endtask

  task automatic modelStep(input logic wr, input logic rd, input logic [2:0] off,
                           input logic [7:0] d, input logic [3:0] hold,
                           input logic [3:0] rel, input logic [3:0] tc,
                           input logic tog);
    int ch;
    ch = int'(d[1:0]);
    mPtr = mPtr ^ tog;
    if (wr) begin
      case (off)
        3'd0: if ((d & 8'hFB) == 8'h00) mCmd = d;
        3'd1: begin mStat[ch+4] = d[2]; mStat[ch] = 1'b0; end
        3'd2: mMask[ch] = d[2];
        3'd3: mMode[ch] = d;
        3'd4: mPtr = 1'b0;
        3'd5: begin mPtr = 1'b0; mMask = 4'hF; mStat = 8'h00; mCmd = 8'h00; end
        3'd6: mMask = 4'h0;
        default: mMask = d[3:0];
      endcase
    end
    if (rd && off == 3'd0) mStat[3:0] = 4'h0;
    mStat[7:4] = (mStat[7:4] & ~rel) | hold;
    mStat[3:0] = mStat[3:0] | tc;
  endtask

  task automatic step(input string tag, input logic wr, input logic rd,
                      input logic [2:0] off, input logic [7:0] d,
                      input logic [3:0] hold, input logic [3:0] rel,
                      input logic [3:0] tc, input logic tog);
    @(negedge clk);
    wrEn = wr; rdEn = rd; regOffset = off; wrData = d;
    dreqHold = hold; dreqRelease = rel; tcIn = tc; ptrToggle = tog;
    #1;
    if (rd) chk({tag, " R7 R8 read"}, 32'(rdData), 32'(expRead(off)));
    else    chk("R8 idle read", 32'(rdData), 32'h0);
    @(posedge clk);
    modelStep(wr, rd, off, d, hold, rel, tc, tog);
    #2;
    chk("R1 R2 cmd", 32'(cmdOut), 32'(mCmd));
    chk("R5 mode", modeFlat, {mMode[3], mMode[2], mMode[1], mMode[0]});
    chk("R12 grant", 32'(grantVec), 32'(expGrant()));
    chk("R13 ptr", 32'(bytePtr), 32'(mPtr));
    wrEn = 0; rdEn = 0; dreqHold = 0; dreqRelease = 0; tcIn = 0; ptrToggle = 0;
  endtask

  task automatic wr(input string tag, input logic [2:0] off, input logic [7:0] d);
    step(tag, 1'b1, 1'b0, off, d, 4'h0, 4'h0, 4'h0, 1'b0);
  endtask

  task automatic rd(input string tag, input logic [2:0] off);
    step(tag, 1'b0, 1'b1, off, 8'h00, 4'h0, 4'h0, 4'h0, 1'b0);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 0; wrEn = 0; rdEn = 0; regOffset = 0; wrData = 0;
    dreqHold = 0; dreqRelease = 0; tcIn = 0; ptrToggle = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R6 hardware reset state
    chk("R6 reset cmd", 32'(cmdOut), 32'h0);
    chk("R6 reset grant", 32'(grantVec), 32'h0);
    chk("R6 reset ptr", 32'(bytePtr), 32'h0);
    rd("R6 status after reset", 3'd0);
    rd("R6 mask after reset", 3'd1);
    rd("R8 other offset", 3'd5);

    // R1 / R2 command acceptance
    wr("R1", 3'd0, 8'h04);
    wr("R2", 3'd0, 8'h10);
    wr("R2", 3'd0, 8'h05);
    wr("R1", 3'd0, 8'h00);

    // R3 request write, R9 clear masks, R12 grant
    wr("R9", 3'd6, 8'h00);
    wr("R3", 3'd1, 8'h06);
    rd("R3 status", 3'd0);
    wr("R3", 3'd1, 8'h05);
    rd("R3 status", 3'd0);
    // R4 single mask on channel 1 moves grant to channel 2
    wr("R4", 3'd2, 8'h05);
    rd("R4 mask", 3'd1);
    wr("R4", 3'd2, 8'h01);
    // R11 tc, then status read clears it (R7)
    step("R11", 1'b0, 1'b0, 3'd0, 8'h0, 4'h0, 4'h0, 4'h8, 1'b0);
    rd("R7 status first", 3'd0);
    rd("R7 status cleared", 3'd0);
    // R11 tc in same cycle as status read wins
    step("R11", 1'b0, 1'b1, 3'd0, 8'h0, 4'h0, 4'h0, 4'h2, 1'b0);
    rd("R11 tc kept", 3'd0);
    // R3 request write clears that channel's tc
    step("R11", 1'b0, 1'b0, 3'd0, 8'h0, 4'h0, 4'h0, 4'h1, 1'b0);
    wr("R3", 3'd1, 8'h04);
    rd("R3 tc cleared", 3'd0);
    // R10 hold/release, hold wins
    step("R10", 1'b0, 1'b0, 3'd0, 8'h0, 4'h8, 4'h7, 4'h0, 1'b0);
    rd("R10 status", 3'd0);
    step("R10", 1'b0, 1'b0, 3'd0, 8'h0, 4'h4, 4'h4, 4'h0, 1'b0);
    rd("R10 status", 3'd0);
    // R9 write all masks
    wr("R9", 3'd7, 8'hFA);
    rd("R9 mask", 3'd1);
    // R5 mode bytes
    wr("R5", 3'd3, 8'h5A);
    wr("R5", 3'd3, 8'hB7);
    // R13 pointer toggle and clear
    step("R13", 1'b0, 1'b0, 3'd0, 8'h0, 4'h0, 4'h0, 4'h0, 1'b1);
    step("R13", 1'b1, 1'b0, 3'd4, 8'h0, 4'h0, 4'h0, 4'h0, 1'b1);
    step("R13", 1'b0, 1'b0, 3'd0, 8'h0, 4'h0, 4'h0, 4'h0, 1'b1);
    // R6 master reset write
    wr("R1", 3'd0, 8'h04);
    wr("R6", 3'd5, 8'h00);
    rd("R6 status", 3'd0);
    rd("R6 mask", 3'd1);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0] off;
      logic [7:0] d;
      logic       w, r;
      off = 3'($urandom_range(0, 7));
      d   = 8'($urandom);
      if (off == 3'd0 && $urandom_range(0, 2) == 0) d = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'h04;
      if (off == 3'd5 && $urandom_range(0, 3) != 0) off = 3'd1;
      w = ($urandom_range(0, 1) == 0);
      r = ($urandom_range(0, 2) == 0);
      step("random", w, r, off, d,
           4'($urandom_range(0, 15) & $urandom_range(0, 15) & $urandom_range(0, 15)),
           4'($urandom_range(0, 15) & $urandom_range(0, 15) & $urandom_range(0, 15)),
           4'($urandom_range(0, 15) & $urandom_range(0, 15)),
           1'($urandom_range(0, 3) == 0));
    end

    finishRun();
  end

endmodule